// File: doc/BRIEF.md
# DDR ADC sample capture and reassembly

The block takes a 16-bit converter sample stream that arrives as double-data-rate bits on eight lanes. Each lane holds two bits of every sample: one is captured on the rising edge of the forwarded data-ready clock and one on its falling edge. The two halves are brought onto the rising edge and joined into one word. That word is pushed into a small synchronous FIFO, and a valid/ready handshake in the same clock domain drains the FIFO.

The clock input is the data-ready strobe after the board or the I/O ring has delayed it to the centre of each bit window. The delay itself is handled outside this block. A runtime swap input corrects a board or capture mapping that has exchanged every odd/even bit pair. When the FIFO is full, new samples are dropped so that the stored ones are kept. A sticky flag records that the captured waveform now has a gap.

Top module: `ddr_adc_capture`

## Requirements
- R1: With swap_en_i low, lane i's rising-edge bit becomes sample bit 2i+1 and its falling-edge bit becomes sample bit 2i.
- R2: With swap_en_i high, lane i's rising-edge bit becomes bit 2i and its falling-edge bit becomes bit 2i+1. The swap value in force is the one present at the rising edge that writes the word into the FIFO.
- R3: One sample is written per clock period. The sample whose rising half is captured at rising edge n and whose falling half is captured at the next falling edge is written at rising edge n+2.
- R4: The FIFO holds 16 samples and returns them in write order. An entry is removed at a rising edge where rd_valid_o and rd_ready_i are both high. Otherwise the head word stays unchanged.
- R5: full_o is high when 16 samples are stored. A write that arrives while full_o is high is dropped, even if a read happens at the same edge. The stored samples are not overwritten, so later reads skip the dropped samples.
- R6: overflow_o goes high after the first edge with a dropped write and stays high until ovf_clr_i is sampled high at an edge with no drop. If a drop and a clear happen at the same edge, the drop takes priority.
- R7: empty_o is high exactly when no sample is stored, and rd_valid_o is its inverse.
- R8: While rst_ni is low, the FIFO is empty, overflow_o is low and all capture stages are invalid, and this takes effect without a clock. The first sample stored after release is the one whose rising half is captured at the first rising edge after release. Any earlier half-sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data-ready strobe, delayed to the centre of the bit window |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_i | input | 8 | DDR data lanes |
| swap_en_i | input | 1 | Exchange odd/even bit of every lane pair |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| rd_ready_i | input | 1 | Consumer accepts the head sample |
| rd_valid_o | output | 1 | Head sample available |
| rd_data_o | output | 16 | Head sample |
| empty_o | output | 1 | No samples stored |
| full_o | output | 1 | 16 samples stored |
| overflow_o | output | 1 | Sticky: a sample was dropped |

## Verification
Every output changes only at a rising edge. The bench drives the rising half of sample n just after falling edge n-1 and the falling half just after rising edge n. It reads all outputs one nanosecond after each falling edge. With continuous reads, the head seen at falling edge n is sample n-2, merged with the swap value that was set during cycle n-1. After reset release, the first two observations must show an empty FIFO. In a stall that starts at cycle a, full_o is first seen at a+15 and overflow_o at a+16. Once reading resumes, the gap first shows 16 reads after the resume: the word read there is sample a+19, not the dropped samples a+14 to a+18. A clear pulse is expected to take effect at the next observation.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned DEPTH_DEF = 16;

  typedef enum logic {
    MAP_NORMAL  = 1'b0,
    MAP_SWAPPED = 1'b1
  } bit_map_e;
endpackage

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] fall_o,
  output logic             pair_v_o
);
  logic [LANES-1:0] rise_q, rise_d, fall_q, fall_rq;
  logic             rise_v, fall_v, pair_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q  <= '0;
      rise_d  <= '0;
      fall_rq <= '0;
      rise_v  <= 1'b0;
      pair_v  <= 1'b0;
    end else begin
      rise_q  <= lane_i;
      rise_d  <= rise_q;   // hold rising half one cycle to meet its falling partner
      fall_rq <= fall_q;   // move falling half onto the rising edge
      rise_v  <= 1'b1;
      pair_v  <= fall_v;
    end
  end

  // falling half is valid only if its rising partner was captured after reset
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q <= '0;
      fall_v <= 1'b0;
    end else begin
      fall_q <= lane_i;
      fall_v <= rise_v;
    end
  end

  assign rise_o   = rise_d;
  assign fall_o   = fall_rq;
  assign pair_v_o = pair_v;
endmodule

// File: rtl/ddr_word_merge.sv
module ddr_word_merge
  import ddr_cap_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned WIDTH = 2 * LANES
) (
  input  logic [LANES-1:0] rise_i,
  input  logic [LANES-1:0] fall_i,
  input  bit_map_e         map_i,
  output logic [WIDTH-1:0] word_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_pair
    always_comb begin
      if (map_i == MAP_SWAPPED) begin
        word_o[2*i+1] = fall_i[i];
        word_o[2*i]   = rise_i[i];
      end else begin
        word_o[2*i+1] = rise_i[i];
        word_o[2*i]   = fall_i[i];
      end
    end
  end
endmodule

// File: rtl/ddr_sample_fifo.sv
module ddr_sample_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_ptr_q, rd_ptr_q;
  logic             push, pop;

  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  // full blocks the write even when a read frees a slot this edge
  assign push    = wr_valid_i && !full_o;
  assign drop_o  = wr_valid_i && full_o;
  assign pop     = rd_ready_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end

  assign rd_valid_o = !empty_o;
  assign rd_data_o  = mem_q[rd_ptr_q[AW-1:0]];
endmodule

// File: rtl/ddr_adc_capture.sv
module ddr_adc_capture
  import ddr_cap_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF,
  localparam int unsigned WIDTH = 2 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  input  logic             swap_en_i,
  input  logic             ovf_clr_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o
);
  logic [LANES-1:0] rise_w, fall_w;
  logic             pair_v;
  logic [WIDTH-1:0] word_w;
  logic             drop_w;
  logic             ovf_q;
  bit_map_e         map_w;

  assign map_w = swap_en_i ? MAP_SWAPPED : MAP_NORMAL;

  ddr_lane_capture #(.LANES(LANES)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_i   (lane_i),
    .rise_o   (rise_w),
    .fall_o   (fall_w),
    .pair_v_o (pair_v)
  );

  ddr_word_merge #(.LANES(LANES)) i_merge (
    .rise_i (rise_w),
    .fall_i (fall_w),
    .map_i  (map_w),
    .word_o (word_w)
  );

  ddr_sample_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (pair_v),
    .wr_data_i  (word_w),
    .rd_ready_i (rd_ready_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .drop_o     (drop_w)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop_w)    ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/ddr_adc_capture_chk.sv
module ddr_adc_capture_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovf_clr_i,
  input logic             rd_ready_i,
  input logic             rd_valid_o,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             overflow_o
);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !ovf_clr_i |=> overflow_o);

  assert_ovf_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !full_o |=> !overflow_o);

  assert_ovf_needs_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overflow_o && !full_o |=> !overflow_o);

  assert_head_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

  assert_full_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_ready_i |=> full_o);

  assert_empty_not_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

bind ddr_adc_capture ddr_adc_capture_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ovf_clr_i  (ovf_clr_i),
  .rd_ready_i (rd_ready_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .overflow_o (overflow_o)
);

// File: tb/test_ddr_adc_capture.sv
module test_ddr_adc_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  lane_i;
  logic        swap_en_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic        rd_ready_i = 1'b1;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic        empty_o, full_o, overflow_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  logic sw_h [4];
  logic        ob_valid, ob_empty, ob_full, ob_ovf;
  logic [15:0] ob_data;

  ddr_adc_capture i_ddr_adc_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_i(lane_i), .swap_en_i(swap_en_i),
    .ovf_clr_i(ovf_clr_i), .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .empty_o(empty_o), .full_o(full_o), .overflow_o(overflow_o)
  );

  always #4 clk_i = ~clk_i;

  // odd multiplier: 65536 consecutive indices cover every code
  function automatic logic [15:0] stim(int n);
    longint p = longint'(n) * 40503;
    return p[15:0];
  endfunction

  function automatic logic [7:0] rise_bits(logic [15:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = w[2*i+1];
    return r;
  endfunction

  function automatic logic [7:0] fall_bits(logic [15:0] w);
    logic [7:0] f;
    for (int i = 0; i < 8; i++) f[i] = w[2*i];
    return f;
  endfunction

  function automatic logic [15:0] exp_merge(logic [15:0] w, logic sw);
    return sw ? (((w & 16'h5555) << 1) | ((w >> 1) & 16'h5555)) : w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic run_cycle(input logic sw, input logic rdy, input logic clr);
    @(posedge clk_i);
    cyc++;
    #1 lane_i = fall_bits(stim(cyc));
    @(negedge clk_i);
    #1;
    ob_valid = rd_valid_o; ob_data = rd_data_o; ob_empty = empty_o;
    ob_full = full_o; ob_ovf = overflow_o;
    lane_i = rise_bits(stim(cyc + 1));
    swap_en_i = sw; sw_h[cyc % 4] = sw;
    rd_ready_i = rdy; ovf_clr_i = clr;
  endtask

  task automatic do_reset(input logic sw);
    rst_ni = 1'b0;
    #1;
    chk(empty_o === 1'b1 && rd_valid_o === 1'b0 && full_o === 1'b0 && overflow_o === 1'b0,
        "R8 reset state", {empty_o, rd_valid_o, full_o, overflow_o}, 4'b1000);
    for (int k = 0; k < 2; k++) run_cycle(sw, 1'b1, 1'b0);
    rst_ni = 1'b1;
  endtask

  // mode 0: straight, 1: swapped, 2: swap toggles
  task automatic sweep(input int n, input int mode);
    for (int k = 0; k < n + 2; k++) begin
      logic sw;
      sw = (mode == 1) ? 1'b1 : (mode == 2) ? logic'(k % 3 == 0) : 1'b0;
      run_cycle(sw, 1'b1, 1'b0);
      if (k < 2) begin
        chk(!ob_valid && ob_empty, "R8 partial half discarded / R7 empty", {ob_valid, ob_empty}, 2'b01);
      end else begin
        logic [15:0] e;
        e = exp_merge(stim(cyc - 2), sw_h[(cyc - 1) % 4]);
        chk(ob_valid && !ob_empty && ob_data == e && !ob_full && !ob_ovf,
            (mode == 0) ? "R1 R3 word order" : "R2 R3 swapped order", ob_data, e);
      end
    end
  endtask

  initial begin
    int a;
    lane_i = rise_bits(stim(1));
    for (int i = 0; i < 4; i++) sw_h[i] = 1'b0;

    do_reset(1'b0);
    sweep(65536, 0);

    // stall: fill, overflow, drain, gap
    for (int k = 0; k <= 40; k++) begin
      run_cycle(1'b0, logic'(k >= 19), 1'b0);
      if (k == 0) a = cyc;
      if (k <= 19) chk(ob_valid && ob_data == stim(a - 2), "R4 head held", ob_data, stim(a - 2));
      if (k == 14) chk(!ob_full, "R5 not full at 15", ob_full, 0);
      if (k == 15) chk(ob_full && !ob_ovf, "R5 full at 16", {ob_full, ob_ovf}, 2'b10);
      if (k == 16) chk(ob_ovf, "R6 overflow set", ob_ovf, 1);
      if (k == 20) chk(!ob_full, "R5 full released", ob_full, 0);
      if (k >= 19 && k <= 34)
        chk(ob_data == stim(a - 2 + (k - 19)), "R4 R5 stored order kept", ob_data, stim(a - 2 + (k - 19)));
      if (k == 35) chk(ob_data == stim(a + 19), "R5 gap after drop", ob_data, stim(a + 19));
      if (k >= 36) chk(ob_ovf, "R6 overflow sticky", ob_ovf, 1);
    end

    run_cycle(1'b0, 1'b1, 1'b1);
    chk(ob_ovf, "R6 before clear", ob_ovf, 1);
    run_cycle(1'b0, 1'b1, 1'b0);
    chk(!ob_ovf, "R6 cleared", ob_ovf, 0);
    run_cycle(1'b0, 1'b1, 1'b0);
    chk(!ob_ovf, "R6 stays clear", ob_ovf, 0);

    // refill to overflow, then reset must clear everything
    for (int k = 0; k < 3; k++) begin
      run_cycle(1'b0, 1'b0, 1'b0);
      if (k == 1) chk(ob_full && !ob_ovf, "R5 refill full", {ob_full, ob_ovf}, 2'b10);
      if (k == 2) chk(ob_ovf, "R6 set again", ob_ovf, 1);
    end
    do_reset(1'b1);
    sweep(65536, 1);
    do_reset(1'b0);
    sweep(300, 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule